// File: doc/BRIEF.md
# Instruction Byte Queue with Queue Status

This block is the small byte buffer that sits between a prefetching bus unit and an execution unit. Each completed code fetch hands it one byte, and the execution unit takes bytes from the head in strict arrival order, at most one per clock. Each read is tagged as the opening byte of an instruction or as a following byte. A flush command drops everything held, which is what a taken branch needs.

Besides the head byte, occupancy and full/empty flags, the block drives a two-bit status code. The code describes what the queue did on the previous clock, so an outside observer can mirror the queue contents. It also gives the architectural instruction pointer. The bus unit's prefetch address counter runs ahead of execution by the number of bytes still queued, so the pointer is that counter minus the occupancy. Bytes already queued are served as they were captured, whatever later happens to memory or to the segment base. Only a flush discards them.

Top module: `iq_byte_queue`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `q_len` is 0, `q_empty` is 1, `q_full` is 0 and `q_stat` is 2'b00.
- R2: A byte written with `wr_en` is not visible during the cycle of the write. After the following rising edge `q_len` has grown by one and, if the queue was empty, `head_byte` shows the new byte.
- R3: Bytes leave in the order they were written. Each accepted read removes exactly one byte at the rising edge, and `head_byte` does not change while no read or flush occurs.
- R4: A read request while `q_empty` is 1 is ignored: `q_len` stays 0 and the next `q_stat` is 2'b00.
- R5: `flush` empties the queue at the next edge (`q_len` 0). A byte written in the same cycle as the flush is discarded as well.
- R6: `q_stat` is registered and reports the previous clock's operation: 2'b00 none, 2'b01 first byte read (`rd_first`=1), 2'b11 subsequent byte read (`rd_first`=0), 2'b10 flush.
- R7: When `flush` and `rd_en` are both high, the flush wins: the queue empties and `q_stat` shows 2'b10.
- R8: A write while the queue holds four bytes and no read is accepted is ignored: `q_len` stays 4 and the queued bytes and their order are unchanged.
- R9: A read and a write in the same cycle on a full queue both take effect: `q_len` stays 4, the head advances, and the new byte joins the tail.
- R10: `ip_out` equals `pc_in` minus `q_len`, modulo 2^20, combinationally.
- R11: `q_full` is 1 exactly when `q_len` is 4, and `q_empty` is 1 exactly when `q_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | A code fetch completed this cycle; store `wr_data` |
| wr_data | input | 8 | Fetched byte |
| rd_en | input | 1 | Execution unit takes the head byte this cycle |
| rd_first | input | 1 | 1: the read byte opens an instruction; 0: a following byte |
| flush | input | 1 | Discard all queued bytes |
| pc_in | input | 20 | Prefetch address counter from the bus unit |
| head_byte | output | 8 | Oldest queued byte (valid when `q_empty` is 0) |
| q_len | output | 3 | Number of queued bytes, 0 to 4 |
| q_full | output | 1 | Queue holds four bytes |
| q_empty | output | 1 | Queue holds no bytes |
| q_stat | output | 2 | Previous clock's queue operation |
| ip_out | output | 20 | Instruction pointer, `pc_in` minus `q_len` |

## Verification
Writes, reads and flushes change `q_len`, the flags and `head_byte` at the first rising edge after the request, and `q_stat` reports that same operation over the cycle that follows that edge. `ip_out` follows `pc_in` and `q_len` with no register. The bench drives inputs on the falling edge, updates its own model at the rising edge from the inputs it applied, and compares every output at the next falling edge. In that way each registered result is sampled exactly one edge after its cause, and the combinational pointer is checked against the occupancy that edge produced.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;
endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/iq_store.sv
module iq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  input  logic                         flush,
  output logic                         rd_take,
  output logic [DW-1:0]                head_byte,
  output logic [$clog2(DEPTH+1)-1:0]   len
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [LW-1:0] len_q, len_d;
  logic          wr_take, is_full, is_empty;

  assign is_full  = (len_q == LW'(DEPTH));
  assign is_empty = (len_q == '0);

  always_comb begin
    rd_take = rd_en && !is_empty && !flush;
    wr_take = wr_en && !flush && (!is_full || rd_take);
    rp_d    = rp_q;
    wp_d    = wp_q;
    len_d   = len_q;
    if (flush) begin
      rp_d  = '0;
      wp_d  = '0;
      len_d = '0;
    end else begin
      if (rd_take) rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (wr_take) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      len_d = len_q + LW'(wr_take) - LW'(rd_take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      len_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      len_q <= len_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_take && (wp_q == PW'(g))) slot_q[g] <= wr_data;
      end
    end
  endgenerate

  assign head_byte = slot_q[rp_q];
  assign len       = len_q;
endmodule

// File: rtl/iq_stat_reg.sv
module iq_stat_reg
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       rd_take,
  input  logic       rd_first,
  output logic [1:0] stat
);
  qstat_e stat_q, stat_d;

  always_comb begin
    if (flush)        stat_d = QS_FLUSH;
    else if (rd_take) stat_d = rd_first ? QS_FIRST : QS_NEXT;
    else              stat_d = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= QS_IDLE;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/iq_ip_calc.sv
module iq_ip_calc #(
  parameter int AW = 20,
  parameter int LW = 3
) (
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] ip
);
  assign ip = pc - {{(AW-LW){1'b0}}, len};
endmodule

// File: rtl/iq_byte_queue.sv
module iq_byte_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = 20,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_first,
  input  logic          flush,
  input  logic [AW-1:0] pc_in,
  output logic [DW-1:0] head_byte,
  output logic [LW-1:0] q_len,
  output logic          q_full,
  output logic          q_empty,
  output logic [1:0]    q_stat,
  output logic [AW-1:0] ip_out
);
  logic rst_n_int;
  logic rd_take;

  iq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  iq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .flush     (flush),
    .rd_take   (rd_take),
    .head_byte (head_byte),
    .len       (q_len)
  );

  iq_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .flush    (flush),
    .rd_take  (rd_take),
    .rd_first (rd_first),
    .stat     (q_stat)
  );

  iq_ip_calc #(.AW(AW), .LW(LW)) u_ip (
    .pc  (pc_in),
    .len (q_len),
    .ip  (ip_out)
  );

  assign q_full  = (q_len == LW'(DEPTH));
  assign q_empty = (q_len == '0);
endmodule

// File: rtl/iq_byte_queue_chk.sv
module iq_byte_queue_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = 20,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          flush,
  input logic [AW-1:0] pc_in,
  input logic [DW-1:0] head_byte,
  input logic [LW-1:0] q_len,
  input logic          q_full,
  input logic          q_empty,
  input logic [1:0]    q_stat,
  input logic [AW-1:0] ip_out
);
  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty) && (q_len <= LW'(DEPTH)));

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> q_empty);

  // R7
  flush_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_stat == 2'b10));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty && !flush) |=> (q_stat == 2'b00));

  // R2
  len_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !flush && !q_full) |=> (q_len == $past(q_len) + 1'b1));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q_full && !rd_en && !flush) |=> (q_full && $stable(head_byte)));

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !flush && !q_empty) |=> $stable(head_byte));

  // R10
  ip_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_out + {{(AW-LW){1'b0}}, q_len}) == pc_in);
endmodule

bind iq_byte_queue iq_byte_queue_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .flush     (flush),
  .pc_in     (pc_in),
  .head_byte (head_byte),
  .q_len     (q_len),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .q_stat    (q_stat),
  .ip_out    (ip_out)
);

// File: tb/iq_byte_queue_tb.sv
module iq_byte_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rd_first = 1'b0, flush = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [19:0] pc_in = 20'h00000;
  logic [7:0]  head_byte;
  logic [2:0]  q_len;
  logic        q_full, q_empty;
  logic [1:0]  q_stat;
  logic [19:0] ip_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] mq [4];
  int         mlen = 0;
  logic [1:0] mstat = 2'b00;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  iq_byte_queue dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_first(rd_first), .flush(flush), .pc_in(pc_in), .head_byte(head_byte),
    .q_len(q_len), .q_full(q_full), .q_empty(q_empty), .q_stat(q_stat), .ip_out(ip_out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "q_len", q_len, mlen);
    chk(req, "q_stat", q_stat, mstat);
    chk("R11", "q_full", q_full, mlen == 4);
    chk("R11", "q_empty", q_empty, mlen == 0);
    chk("R10", "ip_out", ip_out, (pc_in - 20'(mlen)) & 20'hFFFFF);
    if (mlen > 0) chk(req, "head_byte", head_byte, mq[0]);
  endtask

  // model follows the requirements: flush first, then read, then write
  task automatic model_edge();
    if (flush) begin
      mlen = 0; mstat = 2'b10;
    end else begin
      if (rd_en && mlen > 0) begin
        mstat = rd_first ? 2'b01 : 2'b11;
        for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
        mlen--;
      end else mstat = 2'b00;
      if (wr_en && mlen < 4) begin
        mq[mlen] = wr_data; mlen++;
      end
    end
  endtask

  task automatic cyc(input string req, input logic w, input logic [7:0] d,
                     input logic r, input logic f, input logic fl);
    wr_en = w; wr_data = d; rd_en = r; rd_first = f; flush = fl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(req);
    pc_in = pc_in + 20'(w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1", "q_len in reset", q_len, 0);
    chk("R1", "q_empty in reset", q_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    repeat (3) @(negedge clk);
    check_all("R1");
    pc_in = 20'hFFFFE;
    // R2: write is not visible in the same cycle
    wr_en = 1'b1; wr_data = 8'hA0; #1;
    chk("R2", "empty during write", q_empty, 1);
    cyc("R2", 1, 8'hA0, 0, 0, 0);
    for (int i = 1; i < 4; i++) cyc("R2", 1, 8'hA0 + 8'(i), 0, 0, 0);
    // R8: writes into a full queue are dropped
    cyc("R8", 1, 8'hEE, 0, 0, 0);
    cyc("R8", 1, 8'hEF, 0, 0, 0);
    // R9: read and write on a full queue
    cyc("R9", 1, 8'hB4, 1, 1, 0);
    // R3 / R6: drain in order, first then following bytes
    cyc("R3", 0, 8'h00, 1, 0, 0);
    cyc("R6", 0, 8'h00, 1, 1, 0);
    cyc("R3", 0, 8'h00, 1, 0, 0);
    cyc("R3", 0, 8'h00, 1, 0, 0);
    // R4: read from empty
    cyc("R4", 0, 8'h00, 1, 1, 0);
    cyc("R6", 0, 8'h00, 0, 0, 0);
    // R5: flush with a concurrent write
    cyc("R5", 1, 8'h11, 0, 0, 0);
    cyc("R5", 1, 8'h12, 0, 0, 0);
    cyc("R5", 1, 8'h13, 0, 0, 1);
    // R7: flush beats a read
    cyc("R7", 1, 8'h21, 0, 0, 0);
    cyc("R7", 1, 8'h22, 0, 0, 0);
    cyc("R7", 0, 8'h00, 1, 1, 1);
    // sweep of all input combinations from a pseudo-random stream
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R6", lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] & (lfsr[6] | lfsr[2]),
          lfsr[2], (lfsr[7:3] == 5'h1F));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule